// File: doc/BRIEF.md
# Tiered Interrupt Mask and Request Unit

This unit gathers interrupt conditions from the peripherals around a small CPU core. It turns them into one request line per interrupt vector. Sources are sorted into three tiers. Fault and trap sources pass through whatever the core's mask bits say. One external pin is gated only by the core's X mask bit. Every other source is gated by the core's I mask bit.

Timer, pulse-counter and parallel-port events set sticky flag bits. Each flag sits beside an enable bit, and the CPU clears a flag by writing a one to it. Each request output is a level that stays high until its flag is cleared, or until its enable or tier gate drops. Fixed priority among the maskable vectors, stacking and vector fetch belong to the core and are not part of this unit.

Registers are written through a simple strobe port:

| Address | Register |
|---|---|
| 0 | timer flags A |
| 1 | timer enables A |
| 2 | timer flags B, upper nibble |
| 3 | timer enables B, upper nibble |
| 4 | parallel-port control |

Top module: `irq_tier_unit`

## Requirements
- R1: `reqIllop`, `reqCop`, `reqClkMon` and `reqSwi` follow `illopEv`, `copFail`, `clkFail` and `swiReq` combinationally, whatever the values of `xMask` and `iMask`. The software interrupt has no enable.
- R2: `reqXirq` equals `xirqPin` while `xMask` is 0, and is 0 while `xMask` is 1.
- R3: While `iMask` is 1, `reqIrq`, `reqTmrA` and `reqTmrB` are all 0.
- R4: Timer flags A map as follows: compare events `ocEv[0..4]` set bits 7,6,5,4,3, and capture events `icEv[0..2]` set bits 2,1,0. Bit 3 takes `icEv[3]` when `ic4Sel` is 1 and `ocEv[4]` when it is 0. A flag sets on the clock edge that samples its event. `reqTmrA[n]` is flag n AND enable-A bit n AND NOT `iMask`.
- R5: Timer flags B use bit 7 for timer overflow (`tofEv`), bit 6 for the periodic tick (`rtiEv`), bit 5 for pulse-counter overflow and bit 4 for pulse-counter event (`paEv`). `reqTmrB[k]` is flag bit k+4 AND enable-B bit k+4 AND NOT `iMask`.
- R6: A register write to address 0 or 2 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Writes to addresses 1 and 3 load the enables, with address 3 taking data bits 7..4.
- R7: Parallel-port control (address 4) holds the enable in bit 6, and writing 1 to bit 7 clears the port flag. `ppEv` sets the flag. `reqIrq` is (`irqPin` OR (flag AND enable)) AND NOT `iMask`.
- R8: The pulse-counter overflow flag sets on the 256th `paEv` after reset, and not before it.
- R9: When an event and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R10: After reset, all flags, enables and the pulse count are 0, so every gated request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| xMask | input | 1 | Core X mask bit |
| iMask | input | 1 | Core I mask bit |
| illopEv | input | 1 | Illegal opcode condition |
| copFail | input | 1 | Watchdog failure condition |
| clkFail | input | 1 | Clock monitor failure condition |
| swiReq | input | 1 | Software interrupt condition |
| xirqPin | input | 1 | Non-maskable external pin, active high |
| irqPin | input | 1 | Maskable external pin, active high |
| ocEv | input | 5 | Output-compare event strobes |
| icEv | input | 4 | Input-capture event strobes |
| ic4Sel | input | 1 | Shared slot select (1 = capture 4) |
| tofEv | input | 1 | Timer overflow strobe |
| rtiEv | input | 1 | Periodic tick strobe |
| paEv | input | 1 | Pulse-counter event strobe |
| ppEv | input | 1 | Parallel-port event strobe |
| reqIllop | output | 1 | Illegal opcode request |
| reqCop | output | 1 | Watchdog request |
| reqClkMon | output | 1 | Clock monitor request |
| reqSwi | output | 1 | Software interrupt request |
| reqXirq | output | 1 | X-gated pin request |
| reqIrq | output | 1 | Shared pin / parallel-port request |
| reqTmrA | output | 8 | Timer A vector requests |
| reqTmrB | output | 4 | Timer B vector requests (bits 7..4) |

## Verification
Requests from the unmaskable tier and from the two mask gates are combinational, so the bench checks them after inputs settle, with no clock edge in between. Event strobes and register writes act one edge later. The bench drives them one cycle ahead, lets a single rising edge pass and samples just after it. The 256-event overflow is counted edge by edge: the bench checks that the flag is still clear after 255 events and set after the next edge.

// File: rtl/irq_tier_pkg.sv
package irq_tier_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG_A = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN_A   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG_B = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EN_B   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PP     = 3'd4;

  // control-to-datapath strobes
  typedef struct packed {
    logic              wrEnA;
    logic              wrEnB;
    logic              wrPp;
    logic [DATA_W-1:0] clrA;
    logic [3:0]        clrB;
    logic              clrPp;
    logic [DATA_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/irq_tier_ctrl.sv
module irq_tier_ctrl
  import irq_tier_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output strobe_t           strb
);
  always_comb begin
    strb       = '0;
    strb.wdata = regWrData;
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_FLAG_A: strb.clrA  = regWrData;
        ADDR_EN_A:   strb.wrEnA = 1'b1;
        ADDR_FLAG_B: strb.clrB  = regWrData[7:4];
        ADDR_EN_B:   strb.wrEnB = 1'b1;
        ADDR_PP: begin
          strb.wrPp  = 1'b1;
          strb.clrPp = regWrData[7];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_tier_dp.sv
module irq_tier_dp
  import irq_tier_pkg::*;
#(
  parameter int NUM_OC = 5,
  parameter int NUM_IC = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NUM_OC-1:0] ocEv,
  input  logic [NUM_IC-1:0] icEv,
  input  logic              ic4Sel,
  input  logic              tofEv,
  input  logic              rtiEv,
  input  logic              paEv,
  input  logic              ppEv,
  output logic [DATA_W-1:0] flagA,
  output logic [DATA_W-1:0] enA,
  output logic [3:0]        flagB,
  output logic [3:0]        enB,
  output logic              ppFlag,
  output logic              ppEn
);
  localparam int SHARED = DATA_W - NUM_OC;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] setA;
  logic [3:0]        setB;
  logic [CNT_W-1:0]  paCnt;
  logic              paOvf;

  always_comb begin
    setA = '0;
    for (int i = 0; i < NUM_OC - 1; i++) setA[DATA_W-1-i] = ocEv[i];
    for (int i = 0; i < NUM_IC - 1; i++) setA[SHARED-1-i] = icEv[i];
    setA[SHARED] = ic4Sel ? icEv[NUM_IC-1] : ocEv[NUM_OC-1];
  end

  assign paOvf = paEv && (paCnt == CNT_MAX);
  assign setB  = {tofEv, rtiEv, paOvf, paEv};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA  <= '0;
      enA    <= '0;
      flagB  <= '0;
      enB    <= '0;
      ppFlag <= 1'b0;
      ppEn   <= 1'b0;
      paCnt  <= '0;
    end else begin
      flagA  <= (flagA & ~strb.clrA) | setA;
      flagB  <= (flagB & ~strb.clrB) | setB;
      ppFlag <= (ppFlag & ~strb.clrPp) | ppEv;
      if (strb.wrEnA) enA <= strb.wdata;
      if (strb.wrEnB) enB <= strb.wdata[7:4];
      if (strb.wrPp)  ppEn <= strb.wdata[6];
      if (paEv)       paCnt <= paCnt + 1'b1;
    end
  end

  assert_clear_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagA & $past(strb.clrA & ~setA)) == '0));
  assert_clear_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagB & $past(strb.clrB & ~setB)) == '0));
  assert_hold_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagA & ~strb.clrA) & ~flagA) == '0));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(setA) & ~flagA) == '0 && ($past(setB) & ~flagB) == '0));
  assert_pulse_ovf_R8: assert property (@(posedge clk) disable iff (!rstN)
    (paEv && paCnt == CNT_MAX) |=> (flagB[1] && paCnt == '0));
endmodule

// File: rtl/irq_tier_unit.sv
module irq_tier_unit
  import irq_tier_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              xMask,
  input  logic              iMask,
  input  logic              illopEv,
  input  logic              copFail,
  input  logic              clkFail,
  input  logic              swiReq,
  input  logic              xirqPin,
  input  logic              irqPin,
  input  logic [4:0]        ocEv,
  input  logic [3:0]        icEv,
  input  logic              ic4Sel,
  input  logic              tofEv,
  input  logic              rtiEv,
  input  logic              paEv,
  input  logic              ppEv,
  output logic              reqIllop,
  output logic              reqCop,
  output logic              reqClkMon,
  output logic              reqSwi,
  output logic              reqXirq,
  output logic              reqIrq,
  output logic [7:0]        reqTmrA,
  output logic [3:0]        reqTmrB
);
  strobe_t           strb;
  logic [DATA_W-1:0] flagA, enA;
  logic [3:0]        flagB, enB;
  logic              ppFlag, ppEn;

  irq_tier_ctrl u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .strb(strb)
  );

  irq_tier_dp #(.NUM_OC(5), .NUM_IC(4), .CNT_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ocEv(ocEv), .icEv(icEv),
    .ic4Sel(ic4Sel), .tofEv(tofEv), .rtiEv(rtiEv), .paEv(paEv), .ppEv(ppEv),
    .flagA(flagA), .enA(enA), .flagB(flagB), .enB(enB),
    .ppFlag(ppFlag), .ppEn(ppEn)
  );

  // tier 0: no mask
  assign reqIllop  = illopEv;
  assign reqCop    = copFail;
  assign reqClkMon = clkFail;
  assign reqSwi    = swiReq;
  // tier 1: X gate
  assign reqXirq   = xirqPin & ~xMask;
  // tier 2: I gate
  assign reqIrq    = (irqPin | (ppFlag & ppEn)) & ~iMask;
  assign reqTmrA   = flagA & enA & {DATA_W{~iMask}};
  assign reqTmrB   = flagB & enB & {4{~iMask}};

  assert_xgate_R2: assert property (@(posedge clk) disable iff (!rstN)
    xMask |-> !reqXirq);
  assert_igate_R3: assert property (@(posedge clk) disable iff (!rstN)
    iMask |-> (!reqIrq && reqTmrA == '0 && reqTmrB == '0));
  assert_reset_R10: assert property (@(posedge clk)
    $rose(rstN) |-> (reqTmrA == '0 && reqTmrB == '0));
endmodule

// File: tb/irq_tier_unit_tb.sv
module irq_tier_unit_tb;
  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic xMask = 1, iMask = 1;
  logic illopEv = 0, copFail = 0, clkFail = 0, swiReq = 0, xirqPin = 0, irqPin = 0;
  logic [4:0] ocEv = 0;
  logic [3:0] icEv = 0;
  logic ic4Sel = 0, tofEv = 0, rtiEv = 0, paEv = 0, ppEv = 0;
  logic reqIllop, reqCop, reqClkMon, reqSwi, reqXirq, reqIrq;
  logic [7:0] reqTmrA;
  logic [3:0] reqTmrB;
  int total = 0, bad = 0;

  irq_tier_unit u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic do_reset();
    rstN = 0; #12; rstN = 1; tick();
  endtask

  task automatic t_reset();
    do_reset();
    iMask = 0; #1;
    chk("R10 tmrA", reqTmrA, 0);
    chk("R10 tmrB", reqTmrB, 0);
    chk("R10 irq", reqIrq, 0);
  endtask

  task automatic t_unmask();
    xMask = 1; iMask = 1;
    illopEv = 1; copFail = 1; clkFail = 1; swiReq = 1; #1;
    chk("R1 masked", {reqIllop, reqCop, reqClkMon, reqSwi}, 4'hF);
    xMask = 0; iMask = 0; swiReq = 0; copFail = 0; #1;
    chk("R1 clear", {reqIllop, reqCop, reqClkMon, reqSwi}, 4'hA);
    illopEv = 0; clkFail = 0;
  endtask

  task automatic t_xgate();
    xirqPin = 1; xMask = 1; iMask = 0; #1;
    chk("R2 blocked", reqXirq, 0);
    xMask = 0; #1;
    chk("R2 passed", reqXirq, 1);
    iMask = 1; #1;
    chk("R2 I ignored", reqXirq, 1);
    xirqPin = 0;
  endtask

  task automatic t_timerA();
    do_reset();
    iMask = 0;
    wr(3'd1, 8'hFF);
    ocEv = 5'b01111; icEv = 4'b0111; ic4Sel = 1; tick();
    ocEv = 0; icEv = 0;
    chk("R4 oc/ic map", reqTmrA, 8'hF7);
    ocEv = 5'b10000; tick(); ocEv = 0;
    chk("R4 oc5 ignored when sel", reqTmrA, 8'hF7);
    icEv = 4'b1000; tick(); icEv = 0;
    chk("R4 ic4 slot", reqTmrA, 8'hFF);
    wr(3'd0, 8'hFF);
    ic4Sel = 0; icEv = 4'b1000; tick(); icEv = 0;
    chk("R4 ic4 ignored when oc5 sel", reqTmrA, 8'h00);
    ocEv = 5'b10001; tick(); ocEv = 0;
    chk("R4 oc5 slot", reqTmrA, 8'h88);
    wr(3'd1, 8'h08);
    chk("R4 enable mask", reqTmrA, 8'h08);
    iMask = 1; #1;
    chk("R3 tmrA gated", reqTmrA, 8'h00);
    iMask = 0;
  endtask

  task automatic t_timerB();
    do_reset();
    iMask = 0;
    tofEv = 1; rtiEv = 1; tick(); tofEv = 0; rtiEv = 0;
    chk("R5 no enable", reqTmrB, 0);
    wr(3'd3, 8'hF0);
    chk("R5 tof/rti", reqTmrB, 4'hC);
    wr(3'd2, 8'h80);
    chk("R6 clear bit7 only", reqTmrB, 4'h4);
    wr(3'd2, 8'h00);
    chk("R6 zero write keeps", reqTmrB, 4'h4);
    tofEv = 1; regWrEn = 1; regAddr = 3'd2; regWrData = 8'hC0; tick();
    regWrEn = 0; tofEv = 0;
    chk("R9 set wins", reqTmrB, 4'h8);
    iMask = 1; #1;
    chk("R3 tmrB gated", reqTmrB, 0);
    iMask = 0;
  endtask

  task automatic t_pp();
    do_reset();
    iMask = 0;
    ppEv = 1; tick(); ppEv = 0;
    chk("R7 no enable", reqIrq, 0);
    wr(3'd4, 8'h40);
    chk("R7 enabled", reqIrq, 1);
    iMask = 1; #1;
    chk("R3 irq gated", reqIrq, 0);
    iMask = 0;
    wr(3'd4, 8'hC0);
    chk("R7 cleared", reqIrq, 0);
    irqPin = 1; #1;
    chk("R7 pin shares vector", reqIrq, 1);
    irqPin = 0;
  endtask

  task automatic t_pulse();
    do_reset();
    iMask = 0;
    wr(3'd3, 8'h30);
    paEv = 1;
    for (int i = 0; i < 255; i++) tick();
    chk("R8 no ovf at 255", reqTmrB[1], 0);
    chk("R5 pulse edge", reqTmrB[0], 1);
    tick(); paEv = 0;
    chk("R8 ovf at 256", reqTmrB[1], 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_unmask(); t_xgate(); t_timerA();
        t_timerB(); t_pp(); t_pulse();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule